// File: doc/BRIEF.md
# Slave Frame-Sync Error Detector

This block watches the frame-sync line of an audio serial port that runs as a slave to an external bit clock and frame sync. It follows the position inside the frame by counting bit-clock ticks against a configured frame length. It then reports any sync edge that arrives before the frame is complete, and any frame boundary where the expected sync edge is missing. The bit clock reaches the block as a one-cycle `bclk_tick` strobe in the system clock domain. The frame-sync line is sampled only on those ticks.

Software or a neighbouring controller sets the configuration while the monitor is disabled: the frame length minus one, the active level of the sync, and whether the sync edge lands on the first bit of the frame or one bit before it. Tracking starts at the first active sync edge seen after enable. After an early sync the count restarts at that edge. After a missing sync the monitor drops tracking and waits for the next edge. Early and late errors each set a sticky flag, which stays set until its clear strobe. A maskable interrupt line summarises the two flags.

Top module: `fs_slip_monitor`

## Requirements
- R1: After reset, `early_flag`, `late_flag`, `irq` and `in_frame` are 0 and `frame_pos` is 0.
- R2: While `slave_mode` is 0, both flags are forced to 0 from the next clock and `in_frame` is 0, whatever the sync line does.
- R3: After enable, `in_frame` stays 0 and no flag sets until the first active sync edge. An idle line of any length raises no late error.
- R4: The active level is `fs_in` when `fs_active_high` is 1 and `~fs_in` when it is 0. An active edge is a tick where the line is at the active level and was not at the active level on the previous tick.
- R5: An active edge exactly `frame_len_m1`+1 ticks after the previous tracked edge is correct and sets no flag.
- R6: An active edge that comes fewer ticks after the previous edge sets `early_flag`. Tracking continues, and the count restarts at that edge, so frames measured from it are correct.
- R7: A tick with no active edge `frame_len_m1`+1 ticks after the last edge sets `late_flag` and clears `in_frame`. The next active edge restarts tracking.
- R8: While tracking, `frame_pos` gives the bit index of the current tick. With `fs_early_offset` 0, the sync-edge tick is bit 0. With `fs_early_offset` 1, the sync-edge tick is bit `frame_len_m1` and the following tick is bit 0. When not tracking, `frame_pos` is 0.
- R9: Each flag stays set until a one-cycle pulse on its clear strobe (`clr_early`, `clr_late`). If a set and a clear arrive in the same cycle, the set wins.
- R10: `irq` is 1 exactly when (`early_flag` and `irq_en[0]`) or (`late_flag` and `irq_en[1]`).
- R11: While `enable` is 0, `in_frame` is 0 from the next clock, no flag sets, and flags already set keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Monitor enable |
| slave_mode | input | 1 | 1 when the audio block is a timing slave |
| bclk_tick | input | 1 | One-cycle strobe per received bit clock |
| fs_in | input | 1 | Frame-sync line, sampled on ticks |
| frame_len_m1 | input | FRL_W | Frame length in bit clocks minus one |
| fs_active_high | input | 1 | 1: sync active high, 0: active low |
| fs_early_offset | input | 1 | 1: sync edge on the last bit of the previous frame |
| irq_en | input | 2 | Interrupt enables, bit 0 early, bit 1 late |
| clr_early | input | 1 | Clear strobe for the early flag |
| clr_late | input | 1 | Clear strobe for the late flag |
| early_flag | output | 1 | Sticky early-sync error |
| late_flag | output | 1 | Sticky missing-sync error |
| irq | output | 1 | Masked OR of the flags |
| in_frame | output | 1 | Frame tracking active |
| frame_pos | output | FRL_W | Bit index within the current frame |

## Verification
The sync line is driven with several patterns:
- Correctly spaced pulses show that a properly timed frame raises no error.
- A short frame separates the early error from the resynchronised frames that follow it.
- A silenced pulse shows the late error and the loss of tracking, and its reacquisition shows that the next edge restarts tracking.
- Inverted polarity shows that edges are taken on the configured level.
- The same misplaced pulses are replayed with the monitor disabled and in master mode, to show that neither state counts them.
- Runs with both offset settings show where the frame position counter places the sync edge.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   // index of each error kind in flag, set, clear and enable vectors
   typedef enum int unsigned {
      ERR_EARLY = 0,
      ERR_LATE  = 1
   } fsd_err_e;
   localparam int unsigned FSD_NUM_ERR = 2;
endpackage

// File: rtl/fsd_edge.sv
module fsd_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fs_in,
   input  logic active_high,
   output logic edge_seen
);
   logic act_now;
   logic act_prev;

   assign act_now   = active_high ? fs_in : ~fs_in;
   assign edge_seen = tick & act_now & ~act_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_prev <= 1'b0;
      else if (tick) act_prev <= act_now;
   end
endmodule

// File: rtl/fsd_tracker.sv
module fsd_tracker #(
   parameter int unsigned FRL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             edge_seen,
   input  logic [FRL_W-1:0] frame_len_m1,
   input  logic             early_offset,
   output logic             tracking,
   output logic [FRL_W-1:0] frame_pos,
   output logic             early_hit,
   output logic             late_hit
);
   logic [FRL_W-1:0] cnt;
   logic             at_end;

   assign at_end    = (cnt >= frame_len_m1);
   assign early_hit = run & tick & tracking & edge_seen & ~at_end;
   assign late_hit  = run & tick & tracking & ~edge_seen & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tracking <= 1'b0;
         cnt      <= '0;
      end else if (!run) begin
         tracking <= 1'b0;
         cnt      <= '0;
      end else if (tick) begin
         if (!tracking) begin
            if (edge_seen) begin
               tracking <= 1'b1;
               cnt      <= '0;
            end
         end else if (edge_seen) begin
            cnt <= '0;
         end else if (at_end) begin
            tracking <= 1'b0;
            cnt      <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_comb begin
      if (!tracking)         frame_pos = '0;
      else if (!early_offset) frame_pos = cnt;
      else if (cnt == '0)    frame_pos = frame_len_m1;
      else                   frame_pos = cnt - 1'b1;
   end
endmodule

// File: rtl/fsd_flags.sv
module fsd_flags #(
   parameter int unsigned NUM     = 2,
   parameter bit          SET_WIN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold_low,
   input  logic [NUM-1:0] set_in,
   input  logic [NUM-1:0] clr_in,
   input  logic [NUM-1:0] ie,
   output logic [NUM-1:0] flags,
   output logic           irq
);
   for (genvar i = 0; i < NUM; i++) begin : g_flag
      if (SET_WIN) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (hold_low)  flags[i] <= 1'b0;
            else if (set_in[i]) flags[i] <= 1'b1;
            else if (clr_in[i]) flags[i] <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (hold_low)  flags[i] <= 1'b0;
            else if (clr_in[i]) flags[i] <= 1'b0;
            else if (set_in[i]) flags[i] <= 1'b1;
         end
      end
   end

   assign irq = |(flags & ie);
endmodule

// File: rtl/fs_slip_monitor.sv
module fs_slip_monitor #(
   parameter int unsigned FRL_W   = 8,
   parameter bit          SET_WIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             slave_mode,
   input  logic             bclk_tick,
   input  logic             fs_in,
   input  logic [FRL_W-1:0] frame_len_m1,
   input  logic             fs_active_high,
   input  logic             fs_early_offset,
   input  logic [1:0]       irq_en,
   input  logic             clr_early,
   input  logic             clr_late,
   output logic             early_flag,
   output logic             late_flag,
   output logic             irq,
   output logic             in_frame,
   output logic [FRL_W-1:0] frame_pos
);
   import fsd_pkg::*;

   localparam int unsigned NERR = FSD_NUM_ERR;

   if (FRL_W < 3 || FRL_W > 16) begin : g_bad_width
      $error("fs_slip_monitor: FRL_W must lie in 3..16");
   end

   logic            run;
   logic            edge_seen;
   logic            early_hit;
   logic            late_hit;
   logic [NERR-1:0] set_v;
   logic [NERR-1:0] clr_v;
   logic [NERR-1:0] flag_v;

   assign run = enable & slave_mode;

   fsd_edge u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (bclk_tick),
      .fs_in       (fs_in),
      .active_high (fs_active_high),
      .edge_seen   (edge_seen)
   );

   fsd_tracker #(.FRL_W(FRL_W)) u_trk (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .tick         (bclk_tick),
      .edge_seen    (edge_seen),
      .frame_len_m1 (frame_len_m1),
      .early_offset (fs_early_offset),
      .tracking     (in_frame),
      .frame_pos    (frame_pos),
      .early_hit    (early_hit),
      .late_hit     (late_hit)
   );

   always_comb begin
      set_v = '0;
      clr_v = '0;
      set_v[ERR_EARLY] = early_hit;
      set_v[ERR_LATE]  = late_hit;
      clr_v[ERR_EARLY] = clr_early;
      clr_v[ERR_LATE]  = clr_late;
   end

   fsd_flags #(.NUM(NERR), .SET_WIN(SET_WIN)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_low (~slave_mode),
      .set_in   (set_v),
      .clr_in   (clr_v),
      .ie       (irq_en),
      .flags    (flag_v),
      .irq      (irq)
   );

   assign early_flag = flag_v[ERR_EARLY];
   assign late_flag  = flag_v[ERR_LATE];
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
   parameter int unsigned FRL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             slave_mode,
   input logic [1:0]       irq_en,
   input logic             clr_early,
   input logic             early_flag,
   input logic             late_flag,
   input logic             irq,
   input logic             in_frame,
   input logic [FRL_W-1:0] frame_pos
);
   // R2: master mode forces both flags low
   assert_master_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_mode |=> (!early_flag && !late_flag));

   // R11: disabled monitor does not track
   assert_idle_untracked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !in_frame);

   // R9: early flag holds without a clear
   assert_early_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (early_flag && !clr_early) |=> (early_flag || !slave_mode));

   // R7: a late error drops tracking
   assert_late_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(late_flag) |-> !in_frame);

   // R6: an early error keeps tracking
   assert_early_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(early_flag) |-> in_frame);

   // R10: irq only with an enabled flag
   assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((early_flag && irq_en[0]) || (late_flag && irq_en[1])));

   // R8: position is zero when not tracking
   assert_pos_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |-> (frame_pos == '0));
endmodule

bind fs_slip_monitor fsd_checker #(.FRL_W(FRL_W)) u_fsd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .slave_mode (slave_mode),
   .irq_en     (irq_en),
   .clr_early  (clr_early),
   .early_flag (early_flag),
   .late_flag  (late_flag),
   .irq        (irq),
   .in_frame   (in_frame),
   .frame_pos  (frame_pos)
);

// File: tb/tb_fs_slip_monitor.sv
`timescale 1ns/1ps
module tb_fs_slip_monitor;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0, slave_mode = 1'b0, bclk_tick = 1'b0, fs_in = 1'b0;
   logic [W-1:0] frame_len_m1 = 8'd7;
   logic         fs_active_high = 1'b1, fs_early_offset = 1'b0;
   logic [1:0]   irq_en = 2'b00;
   logic         clr_early = 1'b0, clr_late = 1'b0;
   logic         early_flag, late_flag, irq, in_frame;
   logic [W-1:0] frame_pos;

   int checks = 0, errors = 0, cycles = 0;
   bit clr_e_on_tick = 0;

   always #2.5 clk = ~clk;

   fs_slip_monitor #(.FRL_W(W)) dut (.*);

   // behavioural reference
   bit m_pact, m_trk, m_ef, m_lf;
   int m_cnt;
   always @(posedge clk) begin
      bit act, edg, es, ls;
      if (!rst_n) begin
         m_pact = 0; m_trk = 0; m_ef = 0; m_lf = 0; m_cnt = 0;
      end else begin
         act = fs_active_high ? fs_in : !fs_in;
         edg = bclk_tick && act && !m_pact;
         es = 0; ls = 0;
         if (!(enable && slave_mode)) begin
            m_trk = 0; m_cnt = 0;
         end else if (bclk_tick) begin
            if (!m_trk) begin
               if (edg) begin m_trk = 1; m_cnt = 0; end
            end else if (edg) begin
               if (m_cnt < frame_len_m1) es = 1;
               m_cnt = 0;
            end else if (m_cnt >= frame_len_m1) begin
               ls = 1; m_trk = 0; m_cnt = 0;
            end else m_cnt++;
         end
         if (bclk_tick) m_pact = act;
         if (!slave_mode) begin m_ef = 0; m_lf = 0; end
         else begin
            if (es) m_ef = 1; else if (clr_early) m_ef = 0;
            if (ls) m_lf = 1; else if (clr_late) m_lf = 0;
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // per-cycle model comparison
   always @(negedge clk) begin
      int exp_pos, exp_irq;
      cycles++;
      if (rst_n) begin
         exp_pos = !m_trk ? 0 : (!fs_early_offset ? m_cnt :
                   (m_cnt == 0 ? int'(frame_len_m1) : m_cnt - 1));
         exp_irq = int'((m_ef && irq_en[0]) || (m_lf && irq_en[1]));
         chk("R9 early_flag model", int'(early_flag), int'(m_ef));
         chk("R9 late_flag model", int'(late_flag), int'(m_lf));
         chk("R3 in_frame model", int'(in_frame), int'(m_trk));
         chk("R8 frame_pos model", int'(frame_pos), exp_pos);
         chk("R10 irq model", int'(irq), exp_irq);
      end
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step_bit(bit active);
      fs_in = fs_active_high ? active : !active;
      bclk_tick = 1'b1;
      if (clr_e_on_tick) clr_early = 1'b1;
      @(negedge clk);
      bclk_tick = 1'b0;
      clr_early = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_frame(int len);
      step_bit(1);
      for (int i = 1; i < len; i++) step_bit(0);
   endtask

   task automatic pulse_clr(bit e, bit l);
      clr_early = e; clr_late = l;
      @(negedge clk);
      clr_early = 0; clr_late = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 early_flag reset", int'(early_flag), 0);
      chk("R1 late_flag reset", int'(late_flag), 0);
      chk("R1 irq reset", int'(irq), 0);
      chk("R1 in_frame reset", int'(in_frame), 0);

      // R2: master mode ignores misplaced syncs
      enable = 1;
      send_frame(5); send_frame(3); send_frame(8); step_bit(0); step_bit(0);
      chk("R2 early in master", int'(early_flag), 0);
      chk("R2 late in master", int'(late_flag), 0);
      chk("R2 in_frame in master", int'(in_frame), 0);

      // R3: no tracking before first edge
      enable = 0; slave_mode = 1;
      step_bit(0);
      enable = 1;
      for (int i = 0; i < 20; i++) step_bit(0);
      chk("R3 no late while idle", int'(late_flag), 0);
      chk("R3 in_frame idle", int'(in_frame), 0);

      // R5: correct frames
      for (int i = 0; i < 4; i++) send_frame(8);
      chk("R5 early after good frames", int'(early_flag), 0);
      chk("R5 late after good frames", int'(late_flag), 0);
      chk("R5 in_frame", int'(in_frame), 1);
      chk("R8 pos last bit offset0", int'(frame_pos), 7);
      step_bit(1);
      chk("R8 pos sync tick offset0", int'(frame_pos), 0);
      step_bit(0); step_bit(0);
      chk("R8 pos third bit", int'(frame_pos), 2);
      for (int i = 0; i < 5; i++) step_bit(0);

      // R6: early sync and resynchronisation
      send_frame(5);
      step_bit(1);
      chk("R6 early set", int'(early_flag), 1);
      chk("R6 tracking kept", int'(in_frame), 1);
      chk("R6 restart pos", int'(frame_pos), 0);
      for (int i = 0; i < 7; i++) step_bit(0);
      for (int i = 0; i < 3; i++) send_frame(8);
      chk("R6 no late after resync", int'(late_flag), 0);

      // R10: interrupt masking
      irq_en = 2'b01; @(negedge clk);
      chk("R10 irq early enabled", int'(irq), 1);
      irq_en = 2'b10; @(negedge clk);
      chk("R10 irq early masked", int'(irq), 0);

      // R9: clear
      pulse_clr(1, 0);
      chk("R9 early cleared", int'(early_flag), 0);

      // R7: missing sync
      step_bit(0);
      chk("R7 late set", int'(late_flag), 1);
      chk("R7 tracking dropped", int'(in_frame), 0);
      chk("R10 irq late enabled", int'(irq), 1);
      for (int i = 0; i < 6; i++) step_bit(0);
      send_frame(8);
      chk("R7 reacquired", int'(in_frame), 1);
      chk("R7 no early on reacquire", int'(early_flag), 0);
      pulse_clr(0, 1);
      chk("R9 late cleared", int'(late_flag), 0);

      // R9: set wins over clear
      send_frame(3);
      clr_e_on_tick = 1;
      step_bit(1);
      clr_e_on_tick = 0;
      chk("R9 set beats clear", int'(early_flag), 1);
      for (int i = 0; i < 7; i++) step_bit(0);
      pulse_clr(1, 0);

      // R8: one-bit-early offset
      enable = 0; fs_early_offset = 1; step_bit(0);
      enable = 1;
      step_bit(1);
      chk("R8 pos sync tick offset1", int'(frame_pos), 7);
      step_bit(0);
      chk("R8 pos after sync offset1", int'(frame_pos), 0);
      for (int i = 0; i < 6; i++) step_bit(0);
      send_frame(8);
      chk("R8 offset1 no error", int'(early_flag | late_flag), 0);

      // R4: active-low sync
      enable = 0; fs_early_offset = 0; fs_active_high = 0;
      step_bit(0); step_bit(0);
      enable = 1;
      for (int i = 0; i < 3; i++) send_frame(8);
      chk("R4 low polarity tracks", int'(in_frame), 1);
      chk("R4 low polarity clean", int'(early_flag | late_flag), 0);
      send_frame(4); step_bit(1);
      chk("R4 low polarity early", int'(early_flag), 1);
      for (int i = 0; i < 7; i++) step_bit(0);

      // R11: disabled monitor holds flags and ignores syncs
      enable = 0; @(negedge clk);
      chk("R11 in_frame off", int'(in_frame), 0);
      send_frame(3); send_frame(2); for (int i = 0; i < 10; i++) step_bit(0);
      chk("R11 early held", int'(early_flag), 1);
      chk("R11 no late set", int'(late_flag), 0);

      // R2: leaving slave mode clears flags
      slave_mode = 0; @(negedge clk);
      chk("R2 flags cleared in master", int'(early_flag | late_flag), 0);

      repeat (4) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule